// File: doc/BRIEF.md
# Halfword-to-Word Register Access Bridge

This bridge sits between a master with a 16-bit data path and a block of 32-bit registers. Each 32-bit register is seen by the master as two halfwords. Address bit 1 selects the half: 0 is the lower half and 1 is the upper half. The bridge keeps every 32-bit value whole when it is moved in two pieces, so a value is never torn.

Reads:
- A read of the lower half makes exactly one full-word read downstream. It returns bits 15:0 and captures bits 31:16 in the bridge.
- A read of the upper half does not touch the register block. It returns the captured half, so both halves come from the same downstream access.

Writes:
- A write of the lower half only parks the 16 bits inside the bridge.
- A write of the upper half sends one full-word write downstream. That word combines the new upper half with the parked lower half.

Errors:
- Byte-wide accesses are refused with a one-cycle error response. So are accesses to an odd address and cycles that strobe read and write together.
- A refused access leaves both internal halves untouched.

Top module: `hw_split_bridge`

## Requirements
- R1: Address bit 1 selects the half (0 lower, 1 upper). The downstream address equals the master address with bits 1:0 forced to zero.
- R2: A lower-half read (rd=1, wr=0, byte=0, addr[1:0]=00) raises m_rd for exactly the strobe cycle.
- R3: One cycle after a lower-half read, s_rvalid is 1 and s_rdata equals bits 15:0 of m_rdata as seen in the strobe cycle.
- R4: An upper-half read (addr[1:0]=10) does not raise m_rd. One cycle later s_rvalid is 1 and s_rdata equals bits 31:16 captured by the latest lower-half read, or 0 if none has happened since reset. A change of the register contents between the two reads does not alter the result.
- R5: A lower-half write does not raise m_wr. It stores s_wdata in the holding register.
- R6: An upper-half write raises m_wr in the strobe cycle, with m_wdata = {s_wdata, held lower half}. The held half is 0 after reset.
- R7: An access with s_byte=1 or with addr[0]=1 is refused:
  - no m_rd and no m_wr;
  - s_err is 1 for the one cycle after it, with s_rvalid 0;
  - neither the captured upper half nor the held lower half changes.
- R8: A cycle with s_rd and s_wr both 1 is refused exactly as in R7.
- R9: During and just after reset, s_rdata, s_rvalid, s_err, m_rd and m_wr are all 0.
- R10: s_rvalid and s_err are 1 only in the cycle after a matching access, and are 0 in any cycle that follows an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_addr | input | AW (8) | Master byte address |
| s_rd | input | 1 | Master read strobe, one cycle |
| s_wr | input | 1 | Master write strobe, one cycle |
| s_byte | input | 1 | 1 marks a byte-wide access |
| s_wdata | input | HW (16) | Master write data |
| s_rdata | output | HW (16) | Read data, valid with s_rvalid |
| s_rvalid | output | 1 | Read response, cycle after the strobe |
| s_err | output | 1 | Error response, cycle after a refused access |
| m_addr | output | AW (8) | Word-aligned register address |
| m_rd | output | 1 | Full-word read strobe, same cycle as the master strobe |
| m_wr | output | 1 | Full-word write strobe, same cycle as the master strobe |
| m_wdata | output | 2*HW (32) | Full-word write data |
| m_rdata | input | 2*HW (32) | Full-word read data, returned in the strobe cycle |

## Verification
Timing of each result:
- The downstream strobes, address and write data follow the master strobe within the same cycle.
- s_rdata, s_rvalid and s_err are registered, so they are due one edge after the strobe.

How the bench keeps to that timing:
- It drives a strobe just after a falling edge.
- It samples the downstream outputs 1 ns later, still inside the strobe cycle.
- After the next rising edge it drops the strobe, then samples the registered responses, so each response is tied to its own access.
- One more idle cycle is sampled to show that the responses clear again.

// File: rtl/hwb_pkg.sv
// Package: shared access classification for the halfword bridge.
// Assumes one master access per cycle at most.
package hwb_pkg;
    typedef enum logic [2:0] {
        ACC_IDLE  = 3'd0,
        ACC_RD_LO = 3'd1,
        ACC_RD_HI = 3'd2,
        ACC_WR_LO = 3'd3,
        ACC_WR_HI = 3'd4,
        ACC_BAD   = 3'd5
    } acc_kind_t;
endpackage

// File: rtl/hwb_decode.sv
// Module: classifies the master strobe of this cycle into one access kind.
// Assumes: hi_sel is the halfword select bit, misalign is the OR of the
// byte-offset bits below it.
module hwb_decode
    import hwb_pkg::*;
(
    input  logic      rd,
    input  logic      wr,
    input  logic      is_byte,
    input  logic      misalign,
    input  logic      hi_sel,
    output acc_kind_t kind
);
    // Purpose: pick a refused, read or write kind from the strobes.
    always_comb begin
        kind = ACC_IDLE;
        if (rd || wr) begin
            if (is_byte || misalign || (rd && wr))
                kind = ACC_BAD;
            else if (rd)
                kind = hi_sel ? ACC_RD_HI : ACC_RD_LO;
            else
                kind = hi_sel ? ACC_WR_HI : ACC_WR_LO;
        end
    end
endmodule

// File: rtl/hwb_rdpath.sv
// Module: read side. A lower-half read takes the full word from the register
// block, returns its low half and keeps its high half; an upper-half read
// returns the kept half. Assumes m_rdata is valid in the strobe cycle.
module hwb_rdpath
    import hwb_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  acc_kind_t       kind,
    input  logic [2*HW-1:0] m_rdata,
    output logic [HW-1:0]   s_rdata,
    output logic            s_rvalid
);
    logic [HW-1:0] upper_q;

    // Purpose: capture the upper half on every lower-half read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            upper_q <= '0;
        else if (kind == ACC_RD_LO)
            upper_q <= m_rdata[2*HW-1:HW];
    end

    // Purpose: register the returned halfword and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_rdata  <= '0;
            s_rvalid <= 1'b0;
        end else begin
            s_rvalid <= (kind == ACC_RD_LO) || (kind == ACC_RD_HI);
            if (kind == ACC_RD_LO)
                s_rdata <= m_rdata[HW-1:0];
            else if (kind == ACC_RD_HI)
                s_rdata <= upper_q;
        end
    end

    assert_lo_read_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(kind == ACC_RD_LO) |-> (s_rvalid && s_rdata == $past(m_rdata[HW-1:0])));

    assert_hi_read_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(kind == ACC_RD_HI) |-> (s_rvalid && s_rdata == $past(upper_q)));

    assert_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_RD_LO) |=> $stable(upper_q));

    assert_rvalid_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> $past(kind == ACC_RD_LO || kind == ACC_RD_HI));
endmodule

// File: rtl/hwb_wrpath.sv
// Module: write side. A lower-half write is parked; an upper-half write
// emits one full-word write of {new upper, parked lower} in the same cycle.
module hwb_wrpath
    import hwb_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  acc_kind_t       kind,
    input  logic [HW-1:0]   s_wdata,
    output logic            m_wr,
    output logic [2*HW-1:0] m_wdata
);
    logic [HW-1:0] hold_q;

    // Purpose: park the lower half until the upper half arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (kind == ACC_WR_LO)
            hold_q <= s_wdata;
    end

    // Purpose: form the downstream full-word write.
    always_comb begin
        m_wr    = (kind == ACC_WR_HI);
        m_wdata = {s_wdata, hold_q};
    end

    assert_pair_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(kind == ACC_WR_LO) && kind == ACC_WR_HI)
            |-> (m_wr && m_wdata[HW-1:0] == $past(s_wdata)));

    assert_lo_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WR_LO) |-> !m_wr);

    assert_hold_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_WR_LO) |=> $stable(hold_q));
endmodule

// File: rtl/hwb_errresp.sv
// Module: one-cycle error response for refused accesses.
module hwb_errresp
    import hwb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  acc_kind_t kind,
    output logic      s_err
);
    // Purpose: flag a refused access on the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s_err <= 1'b0;
        else
            s_err <= (kind == ACC_BAD);
    end

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_err |-> $past(kind == ACC_BAD));
endmodule

// File: rtl/hw_split_bridge.sv
// Module: top of the halfword-to-word bridge. Assumes the register block
// answers a full-word read combinationally in the strobe cycle and takes a
// write on the edge that ends the strobe cycle.
module hw_split_bridge
    import hwb_pkg::*;
#(
    parameter int AW = 8,
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   s_addr,
    input  logic            s_rd,
    input  logic            s_wr,
    input  logic            s_byte,
    input  logic [HW-1:0]   s_wdata,
    output logic [HW-1:0]   s_rdata,
    output logic            s_rvalid,
    output logic            s_err,
    output logic [AW-1:0]   m_addr,
    output logic            m_rd,
    output logic            m_wr,
    output logic [2*HW-1:0] m_wdata,
    input  logic [2*HW-1:0] m_rdata
);
    localparam int SEL_BIT  = $clog2(HW / 8);
    localparam int WORD_LSB = SEL_BIT + 1;

    acc_kind_t kind;

    hwb_decode u_decode (
        .rd       (s_rd),
        .wr       (s_wr),
        .is_byte  (s_byte),
        .misalign (|s_addr[SEL_BIT-1:0]),
        .hi_sel   (s_addr[SEL_BIT]),
        .kind     (kind)
    );

    hwb_rdpath #(.HW(HW)) u_rdpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .m_rdata  (m_rdata),
        .s_rdata  (s_rdata),
        .s_rvalid (s_rvalid)
    );

    hwb_wrpath #(.HW(HW)) u_wrpath (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .s_wdata (s_wdata),
        .m_wr    (m_wr),
        .m_wdata (m_wdata)
    );

    hwb_errresp u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .s_err (s_err)
    );

    // Purpose: downstream read strobe and word-aligned address.
    always_comb begin
        m_rd   = (kind == ACC_RD_LO);
        m_addr = {s_addr[AW-1:WORD_LSB], {WORD_LSB{1'b0}}};
    end

    assert_bad_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_BAD) |-> (!m_rd && !m_wr));

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m_rd, m_wr}));

    assert_hi_read_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rd && !s_wr && !s_byte && s_addr[WORD_LSB-1:0] == 2'b10) |-> !m_rd);

    assert_addr_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd || m_wr) |-> (m_addr[WORD_LSB-1:0] == '0
                            && m_addr[AW-1:WORD_LSB] == s_addr[AW-1:WORD_LSB]));
endmodule

// File: tb/tb_hw_split_bridge.sv
module tb_hw_split_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  s_addr = '0;
    logic        s_rd = 1'b0, s_wr = 1'b0, s_byte = 1'b0;
    logic [15:0] s_wdata = '0;
    logic [15:0] s_rdata;
    logic        s_rvalid, s_err;
    logic [7:0]  m_addr;
    logic        m_rd, m_wr;
    logic [31:0] m_wdata, m_rdata;

    logic [31:0] regs [4];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // captured values of one access
    logic        c_mrd, c_mwr, c_rvalid, c_err;
    logic [7:0]  c_maddr;
    logic [31:0] c_mwdata;
    logic [15:0] c_rdata;

    always #4 clk = ~clk;

    hw_split_bridge dut (
        .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_rd(s_rd), .s_wr(s_wr),
        .s_byte(s_byte), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .s_rvalid(s_rvalid), .s_err(s_err), .m_addr(m_addr), .m_rd(m_rd),
        .m_wr(m_wr), .m_wdata(m_wdata), .m_rdata(m_rdata)
    );

    // register block model
    assign m_rdata = regs[m_addr[3:2]];
    always @(posedge clk) if (m_wr) regs[m_addr[3:2]] <= m_wdata;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic wr, input logic byt,
                          input logic [7:0] addr, input logic [15:0] wd);
        @(negedge clk);
        s_rd = rd; s_wr = wr; s_byte = byt; s_addr = addr; s_wdata = wd;
        #1;
        c_mrd = m_rd; c_mwr = m_wr; c_maddr = m_addr; c_mwdata = m_wdata;
        @(posedge clk);
        #1;
        s_rd = 0; s_wr = 0; s_byte = 0;
        #1;
        c_rvalid = s_rvalid; c_err = s_err; c_rdata = s_rdata;
    endtask

    task automatic t_reset();
        check("R9", "s_rdata", {16'h0, s_rdata}, 0);
        check("R9", "s_rvalid", {31'h0, s_rvalid}, 0);
        check("R9", "s_err", {31'h0, s_err}, 0);
        check("R9", "m_rd/m_wr", {30'h0, m_rd, m_wr}, 0);
    endtask

    task automatic t_hi_before_lo();
        access(1, 0, 0, 8'h06, 0);
        check("R4", "m_rd on hi read", {31'h0, c_mrd}, 0);
        check("R4", "hi read after reset", {15'h0, c_rvalid, c_rdata}, {15'h0, 1'b1, 16'h0});
    endtask

    task automatic t_read_pair();
        access(1, 0, 0, 8'h04, 0);
        check("R2", "m_rd", {31'h0, c_mrd}, 1);
        check("R1", "m_addr", {24'h0, c_maddr}, 32'h04);
        check("R3", "lo data", {15'h0, c_rvalid, c_rdata}, {15'h0, 1'b1, 16'h1234});
        check("R2", "m_rd one cycle", {31'h0, m_rd}, 0);
        regs[1] = 32'h7777_8888;
        access(1, 0, 0, 8'h06, 0);
        check("R4", "m_rd on hi read", {31'h0, c_mrd}, 0);
        check("R4", "hi data tear-free", {15'h0, c_rvalid, c_rdata}, {15'h0, 1'b1, 16'hA5A5});
    endtask

    task automatic t_write_pair();
        access(0, 1, 0, 8'h08, 16'hBEEF);
        check("R5", "m_wr on lo write", {31'h0, c_mwr}, 0);
        check("R5", "reg untouched", regs[2], 32'h0);
        access(0, 1, 0, 8'h0A, 16'hDEAD);
        check("R6", "m_wr", {31'h0, c_mwr}, 1);
        check("R6", "m_wdata", c_mwdata, 32'hDEAD_BEEF);
        check("R1", "m_addr hi write", {24'h0, c_maddr}, 32'h08);
        check("R6", "reg written", regs[2], 32'hDEAD_BEEF);
        access(1, 0, 0, 8'h08, 0);
        check("R3", "readback lo", {16'h0, c_rdata}, 32'hBEEF);
        access(1, 0, 0, 8'h0A, 0);
        check("R4", "readback hi", {16'h0, c_rdata}, 32'hDEAD);
    endtask

    task automatic t_refused();
        access(1, 0, 1, 8'h04, 0);
        check("R7", "byte read strobes", {30'h0, c_mrd, c_mwr}, 0);
        check("R7", "byte read err/rvalid", {30'h0, c_err, c_rvalid}, 32'h2);
        access(0, 0, 0, 8'h00, 0);
        check("R10", "err clears", {30'h0, s_err, s_rvalid}, 0);
        access(0, 1, 1, 8'h08, 16'h1111);
        check("R7", "byte lo write strobe", {31'h0, c_mwr}, 0);
        check("R7", "byte lo write err", {31'h0, c_err}, 1);
        access(0, 1, 0, 8'h09, 16'h3333);
        check("R7", "odd addr err", {30'h0, c_err, c_mwr}, 32'h2);
        access(1, 1, 0, 8'h08, 16'h5555);
        check("R8", "rd+wr strobes", {30'h0, c_mrd, c_mwr}, 0);
        check("R8", "rd+wr err", {30'h0, c_err, c_rvalid}, 32'h2);
        access(1, 0, 0, 8'h0A, 0);
        check("R7", "upper half kept", {16'h0, c_rdata}, 32'hDEAD);
        access(0, 1, 0, 8'h0E, 16'h2222);
        check("R7", "held half kept", c_mwdata, 32'h2222_BEEF);
        check("R6", "reg3 written", regs[3], 32'h2222_BEEF);
    endtask

    task automatic t_idle();
        access(0, 0, 0, 8'h04, 0);
        check("R10", "idle responses", {30'h0, c_rvalid, c_err}, 0);
    endtask

    initial begin
        regs[0] = 32'h0; regs[1] = 32'hA5A5_1234; regs[2] = 32'h0; regs[3] = 32'h0;
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_hi_before_lo();
        t_read_pair();
        t_write_pair();
        t_refused();
        t_idle();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule